// File: doc/BRIEF.md
# Debug Entry and Fault Capture Unit

This unit sits beside the fetch and load/store stages of a processor core. It watches for the events that can stop the core for a debugger. These are a fetch address that hits one of the instruction breakpoint registers, a breakpoint instruction, a prefetch abort, and an abort during a multi-register data transfer. When the global debug enable bit is set, the unit records why the core stopped and where a fault occurred. The core sees a one-cycle trap pulse for the two breakpoint kinds.

Aborts never raise the trap. They only capture a fault status code and a fault address, and only while debug is enabled. While debug is disabled, no event leaves a trace, and a breakpoint instruction behaves as a no-op. Software can load every register through a simple write port. A hardware capture in the same cycle wins over that write, but only for the registers the capture touches.

Top module: `dbg_entry_unit`

## Requirements
- R1: After a synchronous reset, `trap_o`, `dsr_o`, `fsr_o` and `far_o` are all zero and every instruction breakpoint register is cleared.
- R2: A write with `wr_en` high loads `wr_data` at the next clock edge into the register chosen by `wr_sel`: 0 = debug status, 1 = fault status, 2 = fault address, 4 + k = instruction breakpoint k.
- R3: Instruction breakpoint k matches when `pc_valid` is high, its bit 0 (enable) is set, and its bits [31:2] equal `pc[31:2]`. Register bit 1 and `pc[1:0]` play no part in the match.
- R4: While debug status bit 31 is set, a match raises `trap_o` for the following cycle. It sets debug status bits [4:2] to 3'b001 and keeps all other debug status bits. Fault status and fault address are left unchanged.
- R5: While debug status bit 31 is set, `swbp_evt` raises `trap_o` for the following cycle. It sets debug status bits [4:2] to 3'b011 and keeps the other bits. Fault status becomes 0x400 and fault address becomes `swbp_addr`.
- R6: While debug status bit 31 is clear, no event raises `trap_o` or changes any register.
- R7: While debug is enabled, `pabt_evt` captures fault status 0x400 and fault address `pabt_addr`. It raises no trap and leaves debug status unchanged.
- R8: While debug is enabled, `dabt_evt` captures fault status 0x001 and fault address `dabt_addr`. It raises no trap and leaves debug status unchanged.
- R9: When several events coincide, only the highest one acts. The order from highest is: breakpoint match, then breakpoint instruction, then prefetch abort, then data abort.
- R10: A capture overrides a same-cycle software write to any register it updates. A write to a register the capture leaves alone still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_valid | input | 1 | Fetch address strobe |
| pc | input | 32 | Fetch address |
| swbp_evt | input | 1 | Breakpoint instruction executed |
| swbp_addr | input | 32 | Address of that instruction |
| pabt_evt | input | 1 | Prefetch abort |
| pabt_addr | input | 32 | Address of the aborted fetch |
| dabt_evt | input | 1 | Abort during multi-register transfer |
| dabt_addr | input | 32 | Faulting data address |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| trap_o | output | 1 | Debug trap pulse |
| dsr_o | output | 32 | Debug status register |
| fsr_o | output | 32 | Fault status register |
| far_o | output | 32 | Fault address register |

## Verification
The capture properties assume that a strobe's address is valid in the same cycle as the strobe. They are stated only for cycles in which no higher-priority event is present, so they do not depend on the breakpoint registers' contents. The "disabled means frozen" property also assumes that no software write occurs in that cycle. The bench keeps every address stable across the sampling edge and drives events together as well as alone. Debug status writes keep the enable bit set most of the time, so that both gated and ungated behaviour occur often.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

  // register select codes on the write port
  localparam logic [2:0] SEL_DSR = 3'd0;
  localparam logic [2:0] SEL_FSR = 3'd1;
  localparam logic [2:0] SEL_FAR = 3'd2;
  localparam int unsigned SEL_IBP_BASE = 4;

  // reason codes placed in debug status [4:2]
  localparam logic [2:0] MOE_IBP  = 3'b001;
  localparam logic [2:0] MOE_DBP  = 3'b010;
  localparam logic [2:0] MOE_BKPT = 3'b011;

  // fault status values
  localparam logic [15:0] FS_EXT_ABORT = 16'h0400;
  localparam logic [15:0] FS_XFER      = 16'h0001;

  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_IBP  = 3'd1,
    EV_SWBP = 3'd2,
    EV_PABT = 3'd3,
    EV_DABT = 3'd4
  } dbg_event_e;

endpackage

// File: rtl/dbg_ibp_bank.sv
module dbg_ibp_bank #(
  parameter int unsigned AW      = 32,
  parameter int unsigned NUM_IBP = 2,
  parameter int unsigned SELW    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [AW-1:0]   wr_data,
  input  logic            pc_valid,
  input  logic [AW-3:0]   pc_word,
  output logic            hit
);
  import dbg_entry_pkg::*;

  logic [NUM_IBP-1:0] match;
  logic [NUM_IBP-1:0] unused_bit1;

  for (genvar i = 0; i < NUM_IBP; i++) begin : g_bp
    localparam logic [SELW-1:0] MY_SEL = SELW'(SEL_IBP_BASE + i);
    logic [AW-1:0] bp_q;

    always_ff @(posedge clk) begin
      if (rst)
        bp_q <= '0;
      else if (wr_en && wr_sel == MY_SEL)
        bp_q <= wr_data;
    end

    assign match[i]       = bp_q[0] && (bp_q[AW-1:2] == pc_word);
    assign unused_bit1[i] = bp_q[1];
  end

  logic unused_ok;
  assign unused_ok = ^unused_bit1;

  assign hit = pc_valid && (|match);

endmodule

// File: rtl/dbg_event_arb.sv
module dbg_event_arb (
  input  logic                       dbg_en,
  input  logic                       ibp_hit,
  input  logic                       swbp_evt,
  input  logic                       pabt_evt,
  input  logic                       dabt_evt,
  output dbg_entry_pkg::dbg_event_e  kind
);
  import dbg_entry_pkg::*;

  always_comb begin
    kind = EV_NONE;
    if (dbg_en) begin
      if (ibp_hit)       kind = EV_IBP;
      else if (swbp_evt) kind = EV_SWBP;
      else if (pabt_evt) kind = EV_PABT;
      else if (dabt_evt) kind = EV_DABT;
    end
  end

endmodule

// File: rtl/dbg_capture_regs.sv
module dbg_capture_regs #(
  parameter int unsigned AW   = 32,
  parameter int unsigned SELW = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dbg_entry_pkg::dbg_event_e  kind,
  input  logic [AW-1:0]              swbp_addr,
  input  logic [AW-1:0]              pabt_addr,
  input  logic [AW-1:0]              dabt_addr,
  input  logic                       wr_en,
  input  logic [SELW-1:0]            wr_sel,
  input  logic [AW-1:0]              wr_data,
  output logic                       trap_q,
  output logic [AW-1:0]              dsr_q,
  output logic [AW-1:0]              fsr_q,
  output logic [AW-1:0]              far_q
);
  import dbg_entry_pkg::*;

  localparam logic [SELW-1:0] S_DSR = SELW'(SEL_DSR);
  localparam logic [SELW-1:0] S_FSR = SELW'(SEL_FSR);
  localparam logic [SELW-1:0] S_FAR = SELW'(SEL_FAR);

  logic          is_entry;
  logic          is_fault;
  logic [2:0]    moe;
  logic [AW-1:0] fs_val;
  logic [AW-1:0] fa_val;
  logic [AW-1:0] dsr_entry;

  always_comb begin
    is_entry = 1'b0;
    is_fault = 1'b0;
    moe      = MOE_IBP;
    fs_val   = '0;
    fa_val   = '0;
    unique case (kind)
      EV_IBP: begin
        is_entry = 1'b1;
        moe      = MOE_IBP;
      end
      EV_SWBP: begin
        is_entry = 1'b1;
        is_fault = 1'b1;
        moe      = MOE_BKPT;
        fs_val   = AW'(FS_EXT_ABORT);
        fa_val   = swbp_addr;
      end
      EV_PABT: begin
        is_fault = 1'b1;
        fs_val   = AW'(FS_EXT_ABORT);
        fa_val   = pabt_addr;
      end
      EV_DABT: begin
        is_fault = 1'b1;
        fs_val   = AW'(FS_XFER);
        fa_val   = dabt_addr;
      end
      default: ;
    endcase
  end

  assign dsr_entry = {dsr_q[AW-1:5], moe, dsr_q[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_q <= 1'b0;
      dsr_q  <= '0;
      fsr_q  <= '0;
      far_q  <= '0;
    end else begin
      trap_q <= is_entry;

      if (is_entry)
        dsr_q <= dsr_entry;
      else if (wr_en && wr_sel == S_DSR)
        dsr_q <= wr_data;

      if (is_fault)
        fsr_q <= fs_val;
      else if (wr_en && wr_sel == S_FSR)
        fsr_q <= wr_data;

      if (is_fault)
        far_q <= fa_val;
      else if (wr_en && wr_sel == S_FAR)
        far_q <= wr_data;
    end
  end

endmodule

// File: rtl/dbg_entry_unit.sv
module dbg_entry_unit #(
  parameter int unsigned AW      = 32,
  parameter int unsigned NUM_IBP = 2,
  parameter int unsigned SELW    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_valid,
  input  logic [AW-1:0]   pc,
  input  logic            swbp_evt,
  input  logic [AW-1:0]   swbp_addr,
  input  logic            pabt_evt,
  input  logic [AW-1:0]   pabt_addr,
  input  logic            dabt_evt,
  input  logic [AW-1:0]   dabt_addr,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [AW-1:0]   wr_data,
  output logic            trap_o,
  output logic [AW-1:0]   dsr_o,
  output logic [AW-1:0]   fsr_o,
  output logic [AW-1:0]   far_o
);
  import dbg_entry_pkg::*;

  logic       ibp_hit;
  dbg_event_e kind;
  logic       unused_pc_low;

  assign unused_pc_low = ^pc[1:0];

  dbg_ibp_bank #(.AW(AW), .NUM_IBP(NUM_IBP), .SELW(SELW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .pc_valid (pc_valid),
    .pc_word  (pc[AW-1:2]),
    .hit      (ibp_hit)
  );

  dbg_event_arb u_arb (
    .dbg_en   (dsr_o[AW-1]),
    .ibp_hit  (ibp_hit),
    .swbp_evt (swbp_evt),
    .pabt_evt (pabt_evt),
    .dabt_evt (dabt_evt),
    .kind     (kind)
  );

  dbg_capture_regs #(.AW(AW), .SELW(SELW)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .swbp_addr (swbp_addr),
    .pabt_addr (pabt_addr),
    .dabt_addr (dabt_addr),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .trap_q    (trap_o),
    .dsr_q     (dsr_o),
    .fsr_q     (fsr_o),
    .far_q     (far_o)
  );

endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          pc_valid,
  input logic          swbp_evt,
  input logic [AW-1:0] swbp_addr,
  input logic          pabt_evt,
  input logic [AW-1:0] pabt_addr,
  input logic          dabt_evt,
  input logic [AW-1:0] dabt_addr,
  input logic          wr_en,
  input logic          trap_o,
  input logic [AW-1:0] dsr_o,
  input logic [AW-1:0] fsr_o,
  input logic [AW-1:0] far_o
);

  AST_TRAP_REASON: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (dsr_o[AW-1] && (dsr_o[4:2] == 3'b001 || dsr_o[4:2] == 3'b011))); // R4

  AST_TRAP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> $past(dsr_o[AW-1])); // R6

  AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!dsr_o[AW-1] && !wr_en) |=>
      (!trap_o && $stable(dsr_o) && $stable(fsr_o) && $stable(far_o))); // R6

  AST_BKPT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (dsr_o[AW-1] && swbp_evt && !pc_valid) |=>
      (trap_o && fsr_o == AW'(16'h0400) && far_o == $past(swbp_addr) &&
       dsr_o[4:2] == 3'b011 && dsr_o[AW-1:5] == $past(dsr_o[AW-1:5]))); // R5

  AST_PABT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (dsr_o[AW-1] && pabt_evt && !swbp_evt && !pc_valid) |=>
      (!trap_o && fsr_o == AW'(16'h0400) && far_o == $past(pabt_addr))); // R7

  AST_DABT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (dsr_o[AW-1] && dabt_evt && !pabt_evt && !swbp_evt && !pc_valid) |=>
      (!trap_o && fsr_o == AW'(16'h0001) && far_o == $past(dabt_addr))); // R8

endmodule

bind dbg_entry_unit dbg_entry_chk #(.AW(AW)) u_chk (.*);

// File: tb/dbg_entry_unit_test.sv
`timescale 1ns/1ps
module dbg_entry_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pc_valid = 1'b0;
  logic [31:0] pc = '0;
  logic        swbp_evt = 1'b0;
  logic [31:0] swbp_addr = '0;
  logic        pabt_evt = 1'b0;
  logic [31:0] pabt_addr = '0;
  logic        dabt_evt = 1'b0;
  logic [31:0] dabt_addr = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        trap_o;
  logic [31:0] dsr_o, fsr_o, far_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dbg_entry_unit uut (.*);

  // behavioural reference model
  logic [31:0] m_bp [2];
  logic [31:0] m_dsr, m_fsr, m_far;
  logic        m_trap;
  string       m_tag = "R1";

  function automatic logic [31:0] with_moe(logic [31:0] v, logic [2:0] c);
    logic [31:0] r;
    r = v;
    r[4:2] = c;
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_bp[0] = '0; m_bp[1] = '0;
      m_dsr = '0; m_fsr = '0; m_far = '0; m_trap = 1'b0; m_tag = "R1";
    end else begin
      logic hit;
      logic [31:0] n_dsr, n_fsr, n_far;
      n_dsr = m_dsr; n_fsr = m_fsr; n_far = m_far;
      hit = 1'b0;
      for (int k = 0; k < 2; k++)
        if (pc_valid && m_bp[k][0] && (m_bp[k] >> 2) == (pc >> 2)) hit = 1'b1;
      m_tag = "R2";
      if (wr_en) begin
        case (wr_sel)
          3'd0: n_dsr = wr_data;
          3'd1: n_fsr = wr_data;
          3'd2: n_far = wr_data;
          3'd4: m_bp[0] = wr_data;
          3'd5: m_bp[1] = wr_data;
          default: ;
        endcase
      end
      m_trap = 1'b0;
      if (m_dsr[31]) begin
        if (hit) begin
          n_dsr = with_moe(m_dsr, 3'b001); m_trap = 1'b1; m_tag = "R4";
        end else if (swbp_evt) begin
          n_dsr = with_moe(m_dsr, 3'b011); m_trap = 1'b1;
          n_fsr = 32'h400; n_far = swbp_addr; m_tag = "R5";
        end else if (pabt_evt) begin
          n_fsr = 32'h400; n_far = pabt_addr; m_tag = "R7";
        end else if (dabt_evt) begin
          n_fsr = 32'h1; n_far = dabt_addr; m_tag = "R8";
        end
      end else if (hit || swbp_evt || pabt_evt || dabt_evt) begin
        m_tag = "R6";
      end
      m_dsr = n_dsr; m_fsr = n_fsr; m_far = n_far;
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(m_tag, "trap", {31'd0, trap_o}, {31'd0, m_trap});
      check(m_tag, "dsr", dsr_o, m_dsr);
      check(m_tag, "fsr", fsr_o, m_fsr);
      check(m_tag, "far", far_o, m_far);
    end
  end

  task automatic idle();
    pc_valid = 0; swbp_evt = 0; pabt_evt = 0; dabt_evt = 0; wr_en = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic expect_out(string tag, logic t, logic [31:0] d, logic [31:0] f, logic [31:0] a);
    check(tag, "trap(directed)", {31'd0, trap_o}, {31'd0, t});
    check(tag, "dsr(directed)", dsr_o, d);
    check(tag, "fsr(directed)", fsr_o, f);
    check(tag, "far(directed)", far_o, a);
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0;
    expect_out("R1", 0, 0, 0, 0);

    wr(3'd4, 32'h0000_1001); tick();
    wr(3'd5, 32'h0000_2003); tick();

    pc_valid = 1; pc = 32'h1000; swbp_evt = 1; swbp_addr = 32'h500;
    pabt_evt = 1; pabt_addr = 32'h600; dabt_evt = 1; dabt_addr = 32'h700; tick();
    expect_out("R6", 0, 0, 0, 0);

    wr(3'd0, 32'h8000_0F00); tick();
    expect_out("R2", 0, 32'h8000_0F00, 0, 0);

    pc_valid = 1; pc = 32'h1002; tick();
    expect_out("R4", 1, 32'h8000_0F04, 0, 0);
    pc_valid = 1; pc = 32'h2000; tick();
    expect_out("R3", 1, 32'h8000_0F04, 0, 0);
    pc_valid = 1; pc = 32'h1004; tick();
    expect_out("R3", 0, 32'h8000_0F04, 0, 0);

    swbp_evt = 1; swbp_addr = 32'h3000; tick();
    expect_out("R5", 1, 32'h8000_0F0C, 32'h400, 32'h3000);
    pabt_evt = 1; pabt_addr = 32'h4444; tick();
    expect_out("R7", 0, 32'h8000_0F0C, 32'h400, 32'h4444);
    dabt_evt = 1; dabt_addr = 32'h5558; tick();
    expect_out("R8", 0, 32'h8000_0F0C, 32'h1, 32'h5558);

    pc_valid = 1; pc = 32'h1000; swbp_evt = 1; swbp_addr = 32'h6000;
    pabt_evt = 1; pabt_addr = 32'h7000; dabt_evt = 1; dabt_addr = 32'h8000; tick();
    expect_out("R9", 1, 32'h8000_0F04, 32'h1, 32'h5558);
    swbp_evt = 1; pabt_evt = 1; dabt_evt = 1; tick();
    expect_out("R9", 1, 32'h8000_0F0C, 32'h400, 32'h6000);
    pabt_evt = 1; dabt_evt = 1; tick();
    expect_out("R9", 0, 32'h8000_0F0C, 32'h400, 32'h7000);

    dabt_evt = 1; dabt_addr = 32'h9000; wr(3'd1, 32'hABCD); tick();
    expect_out("R10", 0, 32'h8000_0F0C, 32'h1, 32'h9000);
    pc_valid = 1; pc = 32'h1000; wr(3'd1, 32'h1234); tick();
    expect_out("R10", 1, 32'h8000_0F04, 32'h1234, 32'h9000);
    swbp_evt = 1; swbp_addr = 32'hA000; wr(3'd0, 32'h0); tick();
    expect_out("R10", 1, 32'h8000_0F0C, 32'h400, 32'hA000);

    wr(3'd4, 32'h0000_1000); tick();
    pc_valid = 1; pc = 32'h1000; tick();
    expect_out("R3", 0, 32'h8000_0F0C, 32'h400, 32'hA000);

    wr(3'd0, 32'h0); tick();
    swbp_evt = 1; swbp_addr = 32'hB000; tick();
    expect_out("R6", 0, 32'h0, 32'h400, 32'hA000);

    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      pc_valid = r[0];
      case (r[2:1])
        2'd0: pc = 32'h1000 | {30'd0, r[4:3]};
        2'd1: pc = 32'h2000 | {30'd0, r[4:3]};
        default: pc = $urandom;
      endcase
      swbp_evt = r[5] & r[6]; swbp_addr = $urandom;
      pabt_evt = r[7] & r[8]; pabt_addr = $urandom;
      dabt_evt = r[9];        dabt_addr = $urandom;
      if (r[12:10] == 3'd0) begin
        logic [31:0] d;
        d = $urandom;
        wr_sel = 3'(r[15:13] % 6);
        if (wr_sel == 3'd0) d[31] = (r[17:16] != 2'd0);
        if (wr_sel >= 3'd4) begin d[31:12] = '0; d[11:2] = (r[18] ? 10'h400 : 10'h800) >> 2; end
        wr_en = 1; wr_data = d;
      end
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule